// File: doc/BRIEF.md
# Prescaled Event Counter with Watchdog

This block holds an 8-bit up-counter, an 8-bit prescaler and a watchdog timer that can force a reset. The counter advances either on the instruction-cycle tick or on a chosen edge of an external pin that has already been synchronized. The watchdog advances on a free-running base tick. There is only one prescaler. One bit of the mode register decides whether it divides the counter's events or the watchdog's base ticks.

Software writes an 8-bit mode word. That word selects the divide ratio, the prescaler user, the counter clock source, the external edge polarity and the active-low software watchdog enable. A build-time option can keep the watchdog on at all times, or stop software from ever turning it on. If the watchdog reaches its time-out, the block raises a one-cycle reset pulse and sets a time-out flag. Clear-watchdog and sleep strobes restart the watchdog count. The watchdog period is a parameter, counted in prescaled base ticks.

Top module: `prescaled_timer_wdog`

## Requirements
- R1: After `rst_n` is released, `count_out` is 0x00, `wdog_rst` is 0 and `wdog_flag` is 0. The mode word is 0xFF, so the instruction tick does not advance the counter and the watchdog stays off (when `WDOG_MODE`=0).
- R2: When mode bit 3 is 0, the prescaler belongs to the counter. Mode bits 2:0 = k make the counter advance once every 2^(k+1) counter events, so codes 0..7 give ratios 2 to 256.
- R3: When mode bit 3 is 1, the counter advances on every event. The watchdog then advances once every 2^k base ticks (k = mode bits 2:0), so code 0 gives a 1:1 ratio.
- R4: Mode bit 5 = 0 counts `cyc_tick` cycles. Mode bit 5 = 1 counts edges of `ext_pin` and ignores `cyc_tick`: rising edges when mode bit 4 = 0, falling edges when it is 1.
- R5: `cnt_we` loads `cnt_wdata` into the counter. The load wins over an increment in the same cycle, and it also clears the prescaler.
- R6: The counter wraps from 0xFF to 0x00 and keeps counting.
- R7: On its `WDOG_LIMIT`-th watchdog step, the watchdog drives `wdog_rst` high for exactly one cycle. In the same edge it sets `wdog_flag`, returns the mode word to 0xFF and clears the prescaler. `count_out` is not changed.
- R8: `wdog_clr` and `sleep_req` each zero the watchdog count and clear `wdog_flag`, and either one prevents a time-out in that cycle. `wdog_clr` also clears the prescaler while mode bit 3 is 1.
- R9: The watchdog runs only when it is enabled. With `WDOG_MODE`=0 it is enabled while mode bit 7 is 0. With `WDOG_MODE`=1 it is always enabled. With `WDOG_MODE`=2 it is never enabled. While disabled, its count is held at zero.
- R10: Outside a load, `count_out` changes by at most +1 per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick |
| ext_pin | input | 1 | Synchronized external count input |
| base_tick | input | 1 | Free-running watchdog base tick |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Mode word write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| wdog_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep strobe; also restarts the watchdog |
| count_out | output | 8 | Counter value |
| wdog_rst | output | 1 | One-cycle watchdog time-out reset pulse |
| wdog_flag | output | 1 | Time-out flag |

## Verification
Most of the state is hidden: the prescaler count and the watchdog count never appear at the ports. A prescaler count that is off by one shows up only after a full divide period, as a counter step or a time-out that comes one event early or one event late. For that reason the bench counts events exactly up to each threshold and checks both the last event before the boundary and the boundary itself. A mode word left wrong after a time-out becomes visible on the next instruction ticks, because the counter either advances or does not. A missed clear of the prescaler is caught with a single leftover tick, which moves the time-out earlier by one base tick.

// File: rtl/prescaled_timer_wdog.sv
module prescaled_timer_wdog #(
  parameter int CNT_W      = 8,
  parameter int WDOG_LIMIT = 16,
  parameter int WDOG_MODE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_pin,
  input  logic             base_tick,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             wdog_clr,
  input  logic             sleep_req,
  output logic [CNT_W-1:0] count_out,
  output logic             wdog_rst,
  output logic             wdog_flag
);
  localparam int WD_W = $clog2(WDOG_LIMIT + 1);

  logic [7:0]       mode_q;
  logic [7:0]       ps_q;
  logic [WD_W-1:0]  wd_q;
  logic             pin_q;

  logic [2:0] code;
  logic       ps_to_wd, ext_sel, fall_sel;
  assign code     = mode_q[2:0];
  assign ps_to_wd = mode_q[3];
  assign fall_sel = mode_q[4];
  assign ext_sel  = mode_q[5];

  logic wd_en;
  assign wd_en = (WDOG_MODE == 1) ? 1'b1 :
                 (WDOG_MODE == 2) ? 1'b0 : ~mode_q[7];

  logic edge_ev, cnt_ev;
  assign edge_ev = fall_sel ? (pin_q & ~ext_pin) : (~pin_q & ext_pin);
  assign cnt_ev  = ext_sel ? edge_ev : cyc_tick;

  logic [8:0] mask9;
  logic       ps_in, ps_out;
  assign mask9  = ps_to_wd ? ((9'd1 << code) - 9'd1) : ((9'd2 << code) - 9'd1);
  assign ps_in  = ps_to_wd ? base_tick : cnt_ev;
  assign ps_out = ps_in && ((ps_q & mask9[7:0]) == mask9[7:0]);

  logic cnt_inc, wd_step, wd_restart, expire;
  assign cnt_inc    = ps_to_wd ? cnt_ev : ps_out;
  assign wd_step    = ps_to_wd ? ps_out : base_tick;
  assign wd_restart = wdog_clr | sleep_req;
  assign expire     = wd_en && wd_step && !wd_restart &&
                      (wd_q == WD_W'(WDOG_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'hFF;
      pin_q  <= 1'b0;
    end else begin
      pin_q <= ext_pin;
      if (expire)       mode_q <= 8'hFF;
      else if (mode_we) mode_q <= mode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     ps_q <= '0;
    else if (expire || cnt_we || (wdog_clr && ps_to_wd)) ps_q <= '0;
    else if (ps_in)                                 ps_q <= ps_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_out <= '0;
    else if (cnt_we)  count_out <= cnt_wdata;
    else if (cnt_inc) count_out <= count_out + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q      <= '0;
      wdog_rst  <= 1'b0;
      wdog_flag <= 1'b0;
    end else begin
      wdog_rst <= expire;
      if (wd_restart || !wd_en || expire) wd_q <= '0;
      else if (wd_step)                   wd_q <= wd_q + 1'b1;
      if (expire)          wdog_flag <= 1'b1;
      else if (wd_restart) wdog_flag <= 1'b0;
    end
  end

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);
  assert_mode_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> (mode_q == 8'hFF) && wdog_flag);
  assert_count_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_rst && !$past(cnt_we) && !$past(cnt_inc)) |-> $stable(count_out));
  assert_enabled_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(wd_en));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_clr || sleep_req) |=> !wdog_rst && !wdog_flag && (wd_q == '0));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_out == $past(cnt_wdata)) && (ps_q == '0));
  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_we) |-> (count_out == $past(count_out)) ||
                       (count_out == $past(count_out) + 1'b1));
endmodule

// File: tb/tb_prescaled_timer_wdog.sv
module tb_prescaled_timer_wdog;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_tick = 0, ext_pin = 0, base_tick = 0, mode_we = 0, cnt_we = 0;
  logic wdog_clr = 0, sleep_req = 0;
  logic [7:0] mode_wdata = 0, cnt_wdata = 0;
  logic [7:0] count_out, cnt_on, cnt_off;
  logic wdog_rst, wdog_flag, rst_on, flag_on, rst_off, flag_off;
  int checks = 0, errors = 0;
  int seen = 0, seen_on = 0, seen_off = 0;

  always #10 clk = ~clk;

  prescaled_timer_wdog dut (.clk, .rst_n, .cyc_tick, .ext_pin, .base_tick,
    .mode_we, .mode_wdata, .cnt_we, .cnt_wdata, .wdog_clr, .sleep_req,
    .count_out, .wdog_rst, .wdog_flag);
  prescaled_timer_wdog #(.WDOG_MODE(1)) dut_on (.clk, .rst_n, .cyc_tick, .ext_pin,
    .base_tick, .mode_we, .mode_wdata, .cnt_we, .cnt_wdata, .wdog_clr, .sleep_req,
    .count_out(cnt_on), .wdog_rst(rst_on), .wdog_flag(flag_on));
  prescaled_timer_wdog #(.WDOG_MODE(2)) dut_off (.clk, .rst_n, .cyc_tick, .ext_pin,
    .base_tick, .mode_we, .mode_wdata, .cnt_we, .cnt_wdata, .wdog_clr, .sleep_req,
    .count_out(cnt_off), .wdog_rst(rst_off), .wdog_flag(flag_off));

  always @(negedge clk) begin
    if (wdog_rst) seen++;
    if (rst_on)   seen_on++;
    if (rst_off)  seen_off++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_wdata = v; cnt_we = 1;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_wdata = v; mode_we = 1;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_tick = 1;
      @(negedge clk); cyc_tick = 0;
    end
  endtask
  task automatic bases(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1;
      @(negedge clk); base_tick = 0;
    end
    @(negedge clk);
  endtask
  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1;
      @(negedge clk); ext_pin = 0;
    end
    @(negedge clk);
  endtask
  task automatic strobe_clr(input bit use_sleep);
    @(negedge clk); if (use_sleep) sleep_req = 1; else wdog_clr = 1;
    @(negedge clk); sleep_req = 0; wdog_clr = 0;
  endtask

  // {initial count, mode, instruction ticks, expected count}
  localparam logic [31:0] VEC [8] = '{
    {8'hFE, 8'h80, 8'd6,   8'h01},
    {8'h00, 8'h81, 8'd13,  8'h03},
    {8'h00, 8'h82, 8'd16,  8'h02},
    {8'h00, 8'h83, 8'd47,  8'h02},
    {8'h00, 8'h87, 8'd255, 8'h00},
    {8'h10, 8'h88, 8'd37,  8'h35},
    {8'hFD, 8'h8F, 8'd5,   8'h02},
    {8'h00, 8'h84, 8'd64,  8'h02}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count_out, 0);
    chk("R1 rst", wdog_rst, 0);
    chk("R1 flag", wdog_flag, 0);
    cycles(4);
    chk("R1 mode all ones blocks tick", count_out, 0);
    bases(40);
    chk("R1/R9 watchdog off after reset", seen, 0);

    for (int v = 0; v < 8; v++) begin
      wr_cnt(VEC[v][31:24]);
      wr_mode(VEC[v][23:16]);
      cycles(int'(VEC[v][15:8]));
      @(negedge clk);
      chk($sformatf("R2/R3/R6/R10 vector %0d", v), count_out, VEC[v][7:0]);
    end
    wr_cnt(8'h00); wr_mode(8'h87); cycles(256); @(negedge clk);
    chk("R2 div256 boundary", count_out, 1);

    wr_cnt(8'h00); wr_mode(8'hA8); pin_pulses(3);
    chk("R4 rising edges", count_out, 3);
    cycles(5); @(negedge clk);
    chk("R4 tick ignored on external source", count_out, 3);
    wr_mode(8'hB8); pin_pulses(2);
    chk("R4 falling edges", count_out, 5);
    @(negedge clk); ext_pin = 1; @(negedge clk); @(negedge clk);
    chk("R4 rising ignored in falling mode", count_out, 5);
    ext_pin = 0; @(negedge clk); @(negedge clk);
    chk("R4 falling counted", count_out, 6);

    wr_mode(8'h88);
    @(negedge clk); cyc_tick = 1; cnt_wdata = 8'h77; cnt_we = 1;
    @(negedge clk); cyc_tick = 0; cnt_we = 0;
    chk("R5 load wins over increment", count_out, 8'h77);
    wr_cnt(8'h00); wr_mode(8'h81); cycles(3);
    wr_cnt(8'h00); cycles(3); @(negedge clk);
    chk("R5 load clears prescaler", count_out, 0);
    cycles(1); @(negedge clk);
    chk("R5 fourth event after load", count_out, 1);

    wr_cnt(8'h42); wr_mode(8'h08);
    b = seen; bases(15);
    chk("R7 no time-out before limit", seen - b, 0);
    bases(1);
    chk("R7 time-out at limit", seen - b, 1);
    chk("R7 flag set", wdog_flag, 1);
    chk("R7 count kept", count_out, 8'h42);
    cycles(3); @(negedge clk);
    chk("R7 mode reloaded to all ones", count_out, 8'h42);
    b = seen; bases(40);
    chk("R7/R9 disabled after reload", seen - b, 0);

    wr_mode(8'h08); bases(10); strobe_clr(0);
    chk("R8 clear drops flag", wdog_flag, 0);
    b = seen; bases(15);
    chk("R8 clear restarts count", seen - b, 0);
    bases(1);
    chk("R8 time-out after clear", seen - b, 1);
    wr_mode(8'h08); bases(10); strobe_clr(1);
    chk("R8 sleep drops flag", wdog_flag, 0);
    b = seen; bases(15);
    chk("R8 sleep restarts count", seen - b, 0);
    bases(1);
    chk("R8 time-out after sleep", seen - b, 1);
    wr_mode(8'h09); bases(1); strobe_clr(0);
    b = seen; bases(31);
    chk("R8 clear empties prescaler", seen - b, 0);
    bases(1);
    chk("R8/R3 div2 time-out", seen - b, 1);

    wr_mode(8'h0A);
    b = seen; bases(63);
    chk("R3 watchdog div4 before", seen - b, 0);
    bases(1);
    chk("R3 watchdog div4 at limit", seen - b, 1);

    wr_mode(8'h88);
    b = seen; bases(40);
    chk("R9 bit7 high disables", seen - b, 0);
    wr_mode(8'h8F);
    b = seen_on; bases(2100);
    chk("R9 forced-on build times out", (seen_on - b) > 0, 1);
    chk("R9 forbidden build never times out", seen_off, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule